// File: doc/BRIEF.md
# Eighth-Root Twiddle Constant Multiplier

This block multiplies a complex fixed-point sample by one of two fixed eighth-root twiddle factors used in split-radix FFT butterflies: the factor (√2/2)(1−j) or the factor −(√2/2)(1+j). A one-bit select picks the factor for each sample, so a single datapath serves both. No hardware multiplier is used. The first stage forms the sum and difference of the two input parts at full width. The second stage steers those two values to the real and imaginary lanes, negating one where needed, and scales each lane by √2/2 using a signed-digit shift-add network.

Each lane is multiplied by the integer constant 46341 and divided by 65536, with rounding to nearest. A tie rounds toward plus infinity. The result is then clipped to the signed 16-bit range. The block accepts one sample per cycle and returns each result exactly two cycles later, marked by an output valid flag.

Top module: `tw8_cmul`

## Requirements
- R1: While reset is asserted and until the first result, `out_valid` is 0 and `out_re`/`out_im` are 0.
- R2: A sample taken with `in_valid`=1 at rising edge k produces exactly one result with `out_valid`=1 after rising edge k+2. No result appears without a matching sample.
- R3: With `in_sel`=0 the factor is (√2/2)(1−j). `out_re` ≈ 0.70710678·(a+b) and `out_im` ≈ 0.70710678·(b−a), within ±2 LSB, where a=`in_re` and b=`in_im`.
- R4: With `in_sel`=1 the factor is −(√2/2)(1+j). `out_re` ≈ 0.70710678·(b−a) and `out_im` ≈ −0.70710678·(a+b), within ±2 LSB.
- R5: A scaled value above 32767 gives 32767, and one below −32768 gives −32768. A positive lane never produces a negative result.
- R6: While `in_valid`=0, changes on `in_re`, `in_im` and `in_sel` leave `out_re` and `out_im` at their last result.
- R7: Samples on consecutive cycles, with `in_sel` changing from sample to sample, each produce their own correct result on consecutive cycles.
- R8: The sum a+b and the difference b−a are formed at 17 bits without wrapping. For example a=b=20000 gives a real result of about 28284 with `in_sel`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample present this cycle |
| in_sel | input | 1 | 0: (√2/2)(1−j); 1: −(√2/2)(1+j) |
| in_re | input | 16 | Real part of sample, two's complement |
| in_im | input | 16 | Imaginary part of sample, two's complement |
| out_valid | output | 1 | Result present this cycle |
| out_re | output | 16 | Real part of product, two's complement |
| out_im | output | 16 | Imaginary part of product, two's complement |

## Verification
Every result is due on the second rising edge after its sample is taken. The driver records the cycle number of each sample along with its expected values. The monitor samples on falling edges and requires each popped result to arrive exactly two cycles after its stamp, and it reports any valid output that has no queued sample. Hold behaviour is checked after the pipeline has drained, by comparing the outputs before and after several idle cycles with changing inputs.

// File: rtl/tw8_pkg.sv
package tw8_pkg;

  // Fractional bits of the fixed scaling constant 46341 / 2^16 (~ sqrt(2)/2)
  localparam int FRAC_W  = 16;
  localparam int N_TERMS = 7;

  typedef enum logic {
    TW_FWD = 1'b0,   // (sqrt2/2)(1-j)
    TW_REV = 1'b1    // -(sqrt2/2)(1+j)
  } tw_sel_e;

  // Signed-digit decomposition: 46341 = 2^16 - 2^14 - 2^12 + 2^10 + 2^8 + 2^2 + 2^0
  function automatic int term_shift(input int idx);
    case (idx)
      0: term_shift = 16;
      1: term_shift = 14;
      2: term_shift = 12;
      3: term_shift = 10;
      4: term_shift = 8;
      5: term_shift = 2;
      default: term_shift = 0;
    endcase
  endfunction

  function automatic logic term_neg(input int idx);
    term_neg = (idx == 1) || (idx == 2);
  endfunction

endpackage

// File: rtl/tw8_sumdiff.sv
module tw8_sumdiff #(
  parameter int DATA_W = 16,
  localparam int SUM_W = DATA_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    sel,
  input  logic signed [DATA_W-1:0] a,
  input  logic signed [DATA_W-1:0] b,
  output logic                    vld_q,
  output logic                    sel_q,
  output logic signed [SUM_W-1:0] sum_q,
  output logic signed [SUM_W-1:0] dif_q
);

  logic signed [SUM_W-1:0] a_x, b_x, sum_d, dif_d;

  always_comb begin
    a_x   = {a[DATA_W-1], a};
    b_x   = {b[DATA_W-1], b};
    sum_d = a_x + b_x;
    dif_d = b_x - a_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sel_q <= 1'b0;
      sum_q <= '0;
      dif_q <= '0;
    end else begin
      vld_q <= en;
      if (en) begin
        sel_q <= sel;
        sum_q <= sum_d;
        dif_q <= dif_d;
      end
    end
  end

  // R8
  sum_plus_dif_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ((SUM_W+1)'(sum_q) + (SUM_W+1)'(dif_q)) == ((SUM_W+1)'($past(b)) <<< 1));

  // R6
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(sum_q) && $stable(dif_q)));

endmodule

// File: rtl/tw8_route.sv
module tw8_route #(
  parameter int SUM_W = 17,
  localparam int ARG_W = SUM_W + 1
) (
  input  logic                    sel,
  input  logic signed [SUM_W-1:0] sum,
  input  logic signed [SUM_W-1:0] dif,
  output logic signed [ARG_W-1:0] re_arg,
  output logic signed [ARG_W-1:0] im_arg
);

  import tw8_pkg::*;

  logic signed [ARG_W-1:0] sum_x, dif_x;

  always_comb begin
    sum_x = {sum[SUM_W-1], sum};
    dif_x = {dif[SUM_W-1], dif};
    if (tw_sel_e'(sel) == TW_REV) begin
      re_arg = dif_x;
      im_arg = -sum_x;
    end else begin
      re_arg = sum_x;
      im_arg = dif_x;
    end
  end

endmodule

// File: rtl/tw8_scale.sv
module tw8_scale #(
  parameter int ARG_W  = 18,
  parameter int DATA_W = 16
) (
  input  logic signed [ARG_W-1:0]  x,
  output logic signed [DATA_W-1:0] y
);

  import tw8_pkg::*;

  localparam int PROD_W = ARG_W + FRAC_W + 1;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] MINV = -MAXV - PROD_W'(1);

  logic signed [PROD_W-1:0] x_x, acc, rnd, q;

  always_comb begin
    x_x = {{(PROD_W-ARG_W){x[ARG_W-1]}}, x};
    acc = '0;
    for (int i = 0; i < N_TERMS; i++) begin
      if (term_neg(i)) acc = acc - (x_x <<< term_shift(i));
      else             acc = acc + (x_x <<< term_shift(i));
    end
    rnd = acc + HALF;
    q   = rnd >>> FRAC_W;
    if (q > MAXV)      y = MAXV[DATA_W-1:0];
    else if (q < MINV) y = MINV[DATA_W-1:0];
    else               y = q[DATA_W-1:0];
  end

endmodule

// File: rtl/tw8_cmul.sv
module tw8_cmul #(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sel,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_re,
  output logic signed [DATA_W-1:0] out_im
);

  localparam int SUM_W  = DATA_W + 1;
  localparam int ARG_W  = SUM_W + 1;
  localparam int LANES  = 2;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic                    v1, s1;
  logic signed [SUM_W-1:0] sum1, dif1;

  tw8_sumdiff #(.DATA_W(DATA_W)) u_sumdiff (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (in_valid),
    .sel   (in_sel),
    .a     (in_re),
    .b     (in_im),
    .vld_q (v1),
    .sel_q (s1),
    .sum_q (sum1),
    .dif_q (dif1)
  );

  logic signed [ARG_W-1:0]  lane_arg [LANES];
  logic signed [DATA_W-1:0] lane_res [LANES];

  tw8_route #(.SUM_W(SUM_W)) u_route (
    .sel    (s1),
    .sum    (sum1),
    .dif    (dif1),
    .re_arg (lane_arg[0]),
    .im_arg (lane_arg[1])
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tw8_scale #(.ARG_W(ARG_W), .DATA_W(DATA_W)) u_scale (
      .x (lane_arg[g]),
      .y (lane_res[g])
    );
  end

  logic                     ov_d;
  logic signed [DATA_W-1:0] ore_d, oim_d;

  always_comb begin
    ov_d  = v1;
    ore_d = out_re;
    oim_d = out_im;
    if (v1) begin
      ore_d = lane_res[0];
      oim_d = lane_res[1];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= ov_d;
      out_re    <= ore_d;
      out_im    <= oim_d;
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |-> ##2 out_valid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |-> ##2 !out_valid);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !v1 |=> ($stable(out_re) && $stable(out_im)));

  // R5
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (v1 && lane_arg[0] > 0) |=> !out_re[DATA_W-1]);

endmodule

// File: tb/tw8_cmul_tb.sv
module tw8_cmul_tb;

  localparam real C = 0.70710678;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sel;
  logic signed [15:0] in_re, in_im;
  logic out_valid;
  logic signed [15:0] out_re, out_im;

  always #10 clk = ~clk;

  tw8_cmul u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel),
    .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  typedef struct {
    real   e_re;
    real   e_im;
    int    stamp;
    string req;
  } item_t;

  item_t q[$];
  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  logic [31:0] seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic real clip(input real v);
    if (v > 32767.0)  return 32767.0;
    if (v < -32768.0) return -32768.0;
    return v;
  endfunction

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic send(input int a, input int b, input bit s, input string req);
    item_t it;
    in_valid = 1'b1;
    in_sel   = s;
    in_re    = 16'(a);
    in_im    = 16'(b);
    if (!s) begin
      it.e_re = clip(C * real'(a + b));
      it.e_im = clip(C * real'(b - a));
    end else begin
      it.e_re = clip(C * real'(b - a));
      it.e_im = clip(-C * real'(a + b));
    end
    it.stamp = cyc;
    it.req   = req;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0;
      seed = seed * 32'd1664525 + 32'd1013904223;
      in_re  = seed[15:0];
      in_im  = seed[31:16];
      in_sel = seed[7];
      @(negedge clk);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R2: result with no sample at cycle %0d (actual valid=1, expected 0)", cyc);
      end else begin
        item_t it;
        it = q.pop_front();
        n_tests++;
        if (cyc != it.stamp + 2) begin
          n_fail++;
          $display("FAIL R2: latency actual %0d expected 2", cyc - it.stamp);
        end else if (absr(real'(out_re) - it.e_re) > 2.0 || absr(real'(out_im) - it.e_im) > 2.0) begin
          n_fail++;
          $display("FAIL %s: actual (%0d,%0d) expected (%0.2f,%0.2f)",
                   it.req, out_re, out_im, it.e_re, it.e_im);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic signed [15:0] h_re, h_im;
    rst_n = 1'b0; in_valid = 1'b0; in_sel = 1'b0; in_re = '0; in_im = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_tests++;
    if (out_valid !== 1'b0 || out_re !== 16'sd0 || out_im !== 16'sd0) begin
      n_fail++;
      $display("FAIL R1: actual (%0b,%0d,%0d) expected (0,0,0)", out_valid, out_re, out_im);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || out_re !== 16'sd0 || out_im !== 16'sd0) begin
      n_fail++;
      $display("FAIL R1: after release actual (%0b,%0d,%0d) expected (0,0,0)", out_valid, out_re, out_im);
    end

    // R3
    send(1000, 0, 1'b0, "R3");     idle(2);
    send(100, 200, 1'b0, "R3");    idle(1);
    send(-5000, 3000, 1'b0, "R3"); idle(3);
    // R4
    send(1000, 0, 1'b1, "R4");     idle(2);
    send(-7000, -1234, 1'b1, "R4"); idle(2);
    // R5 saturation
    send(32767, 32767, 1'b0, "R5");   idle(1);
    send(-32768, -32768, 1'b0, "R5"); idle(1);
    send(-32768, -32768, 1'b1, "R5"); idle(1);
    send(32767, -32768, 1'b0, "R5");  idle(2);
    // R8 no wrap of 17-bit sums
    send(20000, 20000, 1'b0, "R8");  idle(1);
    send(-30000, 25000, 1'b1, "R8"); idle(2);
    // R7 back-to-back with alternating select
    for (int i = 0; i < 40; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      send(int'($signed(seed[15:0])), int'($signed(seed[31:16])), i[0], "R7");
    end
    idle(4);

    // R6: hold while idle with changing inputs
    h_re = out_re; h_im = out_im;
    idle(6);
    n_tests++;
    if (out_re !== h_re || out_im !== h_im) begin
      n_fail++;
      $display("FAIL R6: actual (%0d,%0d) expected (%0d,%0d)", out_re, out_im, h_re, h_im);
    end
    // R2: every queued sample returned
    n_tests++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: pending results actual %0d expected 0", q.size());
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule